// File: doc/BRIEF.md
# Stream Write Flush Controller

This block sits between a streaming write source and the FIFO that feeds a burst memory write engine. By default it discards every incoming beat while still accepting it, so the source never stalls and the FIFO never fills while no write access is pending. Software or a packet-level controller arms a write access with a start address and a word count. From then on the block waits for a release beat and admits data into the FIFO until the programmed number of words has gone in. It then reports completion and returns to discarding.

A build-time parameter decides which beat may end discarding: any valid beat, a valid beat marked start-of-packet, or a valid beat marked sync. A direction input tells the block whether the memory port is writing or reading. While it is reading, all write-stream data is discarded and any access in progress is dropped. The done pulse can be fed back to the source as an xon-style go-ahead for the next block of data.

Top module: `wrflush_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `flush_active` is 1, `done` is 0, `fifo_wr` is 0, `snk_ready` is 1 and `wr_addr` is 0.
- R2: While no access is armed, `snk_ready` is 1 and `fifo_wr` is 0 whatever the sink inputs are.
- R3: `arm_en` with `dir_wr`=1 and a nonzero `arm_words`, sampled while idle, loads `arm_addr` onto `wr_addr` from the next cycle on. Discarding continues until a release beat arrives.
- R4: The release beat is chosen by `MODE`: 0 = any valid beat, 1 = valid with `snk_sop`=1, 2 = valid with `snk_sync`=1. While armed, beats that are not release beats are discarded with `snk_ready`=1.
- R5: A release beat that arrives while `fifo_afull`=0 is written in the same cycle, with `fifo_data` equal to `snk_data`, and counts as word 1. If `fifo_afull`=1 it is discarded and the block keeps waiting.
- R6: Once released, `snk_ready` equals the inverse of `fifo_afull`, and `fifo_wr` is high exactly when `snk_valid` and `snk_ready` are both high.
- R7: The cycle after the word that completes the count is written, `done` is 1 for exactly one cycle and the block is idle again, with discarding on.
- R8: `dir_wr`=0 forces `snk_ready`=1 and `fifo_wr`=0. An armed or running access is dropped without `done`, and the block is idle the next cycle.
- R9: `arm_en` is ignored while `dir_wr`=0, when `arm_words` is 0, and while an access is armed or running. `wr_addr` keeps its value in each of these cases.
- R10: `flush_active` is 1 while idle or armed and 0 from the cycle after the release beat until the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_wr | input | 1 | 1 = memory port writes, 0 = memory port reads |
| arm_en | input | 1 | Pulse arming a write access |
| arm_addr | input | ADDR_W | Start address of the access |
| arm_words | input | CNT_W | Number of words to admit |
| snk_valid | input | 1 | Stream beat valid |
| snk_sop | input | 1 | Beat is start of packet |
| snk_sync | input | 1 | Beat carries the sync mark |
| snk_data | input | DATA_W | Beat payload |
| snk_ready | output | 1 | Stream ready |
| fifo_afull | input | 1 | FIFO almost full |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | DATA_W | FIFO write data |
| flush_active | output | 1 | Incoming beats are being discarded |
| done | output | 1 | One-cycle completion pulse |
| wr_addr | output | ADDR_W | Start address of the armed access |

## Verification
Two events can fall in the same cycle: the final word of an access being written, and a new `arm_en` arriving. The bench forces this by raising `arm_en` exactly on the completing beat, which must be ignored, and again on the cycle `done` is high, which must be accepted with the new address appearing one cycle later. A behavioural model built from queues of integers predicts every output on every clock for all three release modes, driven side by side from the same stimulus. The same model judges a direction flip landing on a release beat and a release beat landing on almost-full.

// File: rtl/wrflush_pkg.sv
// Shared types for the stream write flush controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package wrflush_pkg;

    // Which stream beat may end a flush and start admission
    typedef enum logic [1:0] {
        REL_ON_VALID = 2'd0,
        REL_ON_SOP   = 2'd1,
        REL_ON_SYNC  = 2'd2
    } rel_mode_e;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PASS  = 2'd2
    } flush_st_e;

endpackage

// File: rtl/wrflush_boundary.sv
// Release-beat detector: flags a valid beat that may end a flush.
// The variant is picked at build time by MODE; purely combinational.
module wrflush_boundary
    import wrflush_pkg::*;
#(
    parameter rel_mode_e MODE = REL_ON_SOP
) (
    input  logic valid,
    input  logic sop,
    input  logic sync,
    output logic hit
);

    generate
        if (MODE == REL_ON_VALID) begin : g_on_valid
            // any valid beat releases
            logic unused_marks;
            assign unused_marks = sop | sync;
            assign hit = valid;
        end else if (MODE == REL_ON_SYNC) begin : g_on_sync
            // only a sync-marked beat releases
            logic unused_marks;
            assign unused_marks = sop;
            assign hit = valid & sync;
        end else begin : g_on_sop
            // only a start-of-packet beat releases
            logic unused_marks;
            assign unused_marks = sync;
            assign hit = valid & sop;
        end
    endgenerate

endmodule

// File: rtl/wrflush_count.sv
// Holds the armed access (start address, word target) and counts the
// words admitted so far. Assumes load, clr and adv come from the FSM;
// load wins over clr, clr wins over adv.
module wrflush_count #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clr,
    input  logic              adv,
    input  logic [CNT_W-1:0]  words,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              is_last
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt + 1'b1;
    assign is_last = (cnt_inc == target);

    // Purpose: capture the armed access and advance the admitted-word count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            target  <= '0;
            wr_addr <= '0;
        end else if (load) begin
            cnt     <= '0;
            target  <= words;
            wr_addr <= addr_in;
        end else if (clr) begin
            cnt     <= '0;
        end else if (adv) begin
            cnt     <= cnt_inc;
        end
    end

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && !load) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/wrflush_fsm.sv
// Flush state machine: idle (discard), armed (discard, wait for release
// beat), pass (admit under FIFO back-pressure). Assumes is_last reflects
// the word about to be written in the current cycle.
module wrflush_fsm
    import wrflush_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dir_wr,
    input  logic arm_en,
    input  logic words_nz,
    input  logic hit,
    input  logic snk_valid,
    input  logic fifo_afull,
    input  logic is_last,
    output logic snk_ready,
    output logic fifo_wr,
    output logic flush_active,
    output logic done,
    output logic load,
    output logic clr
);

    flush_st_e st, st_nxt;
    logic      finish;
    logic      abort;

    // Purpose: decode handshake, arming and end-of-access from the state
    always_comb begin
        snk_ready = 1'b1;
        fifo_wr   = 1'b0;
        load      = 1'b0;
        case (st)
            ST_IDLE: begin
                load = dir_wr & arm_en & words_nz;
            end
            ST_ARMED: begin
                fifo_wr = dir_wr & hit & ~fifo_afull;
            end
            ST_PASS: begin
                snk_ready = dir_wr ? ~fifo_afull : 1'b1;
                fifo_wr   = dir_wr & snk_valid & ~fifo_afull;
            end
            default: ;
        endcase
        finish = fifo_wr & is_last;
        abort  = ~dir_wr & (st != ST_IDLE);
        clr    = finish | abort;
    end

    // Purpose: choose the next state
    always_comb begin
        st_nxt = st;
        case (st)
            ST_IDLE:  if (load) st_nxt = ST_ARMED;
            ST_ARMED: begin
                if (abort)        st_nxt = ST_IDLE;
                else if (finish)  st_nxt = ST_IDLE;
                else if (fifo_wr) st_nxt = ST_PASS;
            end
            ST_PASS:  if (abort || finish) st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    // Purpose: hold the state and the registered done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            done <= 1'b0;
        end else begin
            st   <= st_nxt;
            done <= finish;
        end
    end

    assign flush_active = (st != ST_PASS);

    assert_idle_discard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (snk_ready && !fifo_wr));

    assert_wr_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (snk_valid && snk_ready && !fifo_afull));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_follows_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fifo_wr));

    assert_read_drops_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_wr && st != ST_IDLE) |=> (st == ST_IDLE && !done));

endmodule

// File: rtl/wrflush_ctrl.sv
// Stream write flush controller top. Discards write-stream beats unless
// a write access is armed and released; admits the programmed number of
// words into the FIFO, then pulses done. Assumes the FIFO asserts
// fifo_afull early enough to absorb one more write.
module wrflush_ctrl
    import wrflush_pkg::*;
#(
    parameter int        DATA_W = 32,
    parameter int        ADDR_W = 32,
    parameter int        CNT_W  = 16,
    parameter rel_mode_e MODE   = REL_ON_SOP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_wr,
    input  logic              arm_en,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic [CNT_W-1:0]  arm_words,
    input  logic              snk_valid,
    input  logic              snk_sop,
    input  logic              snk_sync,
    input  logic [DATA_W-1:0] snk_data,
    output logic              snk_ready,
    input  logic              fifo_afull,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data,
    output logic              flush_active,
    output logic              done,
    output logic [ADDR_W-1:0] wr_addr
);

    logic hit;
    logic is_last;
    logic load;
    logic clr;
    logic words_nz;

    assign words_nz  = |arm_words;
    assign fifo_data = snk_data;

    wrflush_boundary #(.MODE(MODE)) u_boundary (
        .valid (snk_valid),
        .sop   (snk_sop),
        .sync  (snk_sync),
        .hit   (hit)
    );

    wrflush_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .dir_wr       (dir_wr),
        .arm_en       (arm_en),
        .words_nz     (words_nz),
        .hit          (hit),
        .snk_valid    (snk_valid),
        .fifo_afull   (fifo_afull),
        .is_last      (is_last),
        .snk_ready    (snk_ready),
        .fifo_wr      (fifo_wr),
        .flush_active (flush_active),
        .done         (done),
        .load         (load),
        .clr          (clr)
    );

    wrflush_count #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .clr     (clr),
        .adv     (fifo_wr),
        .words   (arm_words),
        .addr_in (arm_addr),
        .wr_addr (wr_addr),
        .is_last (is_last)
    );

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_active |=> $stable(wr_addr));

endmodule

// File: tb/wrflush_ctrl_bench.sv
`timescale 1ns/1ps
module wrflush_ctrl_bench;
    import wrflush_pkg::*;

    localparam int DW = 16;
    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dir_wr = 1'b1, arm_en = 1'b0;
    logic [AW-1:0] arm_addr = '0;
    logic [CW-1:0] arm_words = '0;
    logic          snk_valid = 1'b0, snk_sop = 1'b0, snk_sync = 1'b0;
    logic [DW-1:0] snk_data = '0;
    logic          fifo_afull = 1'b0;

    logic          rdy [3];
    logic          wr  [3];
    logic          fl  [3];
    logic          dn  [3];
    logic [DW-1:0] fd  [3];
    logic [AW-1:0] wa  [3];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    wrflush_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .MODE(REL_ON_VALID)) u_wrflush_ctrl_val (
        .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .arm_en(arm_en), .arm_addr(arm_addr),
        .arm_words(arm_words), .snk_valid(snk_valid), .snk_sop(snk_sop), .snk_sync(snk_sync),
        .snk_data(snk_data), .snk_ready(rdy[0]), .fifo_afull(fifo_afull), .fifo_wr(wr[0]),
        .fifo_data(fd[0]), .flush_active(fl[0]), .done(dn[0]), .wr_addr(wa[0]));

    wrflush_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .MODE(REL_ON_SOP)) u_wrflush_ctrl (
        .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .arm_en(arm_en), .arm_addr(arm_addr),
        .arm_words(arm_words), .snk_valid(snk_valid), .snk_sop(snk_sop), .snk_sync(snk_sync),
        .snk_data(snk_data), .snk_ready(rdy[1]), .fifo_afull(fifo_afull), .fifo_wr(wr[1]),
        .fifo_data(fd[1]), .flush_active(fl[1]), .done(dn[1]), .wr_addr(wa[1]));

    wrflush_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .MODE(REL_ON_SYNC)) u_wrflush_ctrl_sync (
        .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .arm_en(arm_en), .arm_addr(arm_addr),
        .arm_words(arm_words), .snk_valid(snk_valid), .snk_sop(snk_sop), .snk_sync(snk_sync),
        .snk_data(snk_data), .snk_ready(rdy[2]), .fifo_afull(fifo_afull), .fifo_wr(wr[2]),
        .fifo_data(fd[2]), .flush_active(fl[2]), .done(dn[2]), .wr_addr(wa[2]));

    // Behavioural reference: 0 idle, 1 armed, 2 passing
    int            m_st  [3];
    int            m_cnt [3];
    int            m_tgt [3];
    bit            m_dn  [3];
    logic [AW-1:0] m_ad  [3];

    task automatic chk(input string rq, input string tag, input int m, input string nm,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) inst%0d %s actual=%0h expected=%0h", rq, tag, m, nm, act, exp);
        end
    endtask

    // One clock: drive at negedge, compare before the edge, advance model
    task automatic step(input bit rn, input bit arm, input bit dir, input logic [AW-1:0] a,
                        input int w, input bit v, input bit sp, input bit sy, input bit af,
                        input logic [DW-1:0] d, input string tag);
        @(negedge clk);
        rst_n = rn; arm_en = arm; dir_wr = dir; arm_addr = a; arm_words = CW'(w);
        snk_valid = v; snk_sop = sp; snk_sync = sy; fifo_afull = af; snk_data = d;
        #2;
        for (int m = 0; m < 3; m++) begin
            bit bnd, e_rdy, e_wr;
            string rq;
            bnd   = v && (m == 0 || (m == 1 && sp) || (m == 2 && sy));
            e_rdy = (m_st[m] == 2 && dir) ? !af : 1'b1;
            e_wr  = dir && !af && ((m_st[m] == 1 && bnd) || (m_st[m] == 2 && v));
            if (rn) begin
                rq = !dir ? "R8" : (m_st[m] == 0 ? "R2" : (m_st[m] == 1 ? "R4" : "R6"));
                chk(rq, tag, m, "snk_ready", rdy[m], e_rdy);
                chk(rq, tag, m, "fifo_wr", wr[m], e_wr);
                chk("R10", tag, m, "flush_active", fl[m], m_st[m] != 2);
                chk("R7", tag, m, "done", dn[m], m_dn[m]);
                chk("R3", tag, m, "wr_addr", wa[m], m_ad[m]);
                if (e_wr) chk("R5", tag, m, "fifo_data", fd[m], d);
            end
            if (!rn) begin
                m_st[m] = 0; m_cnt[m] = 0; m_tgt[m] = 0; m_dn[m] = 0; m_ad[m] = '0;
            end else begin
                m_dn[m] = 0;
                if (!dir) begin
                    m_st[m] = 0; m_cnt[m] = 0;
                end else if (m_st[m] == 0) begin
                    if (arm && w != 0) begin
                        m_st[m] = 1; m_tgt[m] = w; m_ad[m] = a; m_cnt[m] = 0;
                    end
                end else if (e_wr) begin
                    if (m_cnt[m] + 1 == m_tgt[m]) begin
                        m_st[m] = 0; m_cnt[m] = 0; m_dn[m] = 1;
                    end else begin
                        m_st[m] = 2; m_cnt[m] = m_cnt[m] + 1;
                    end
                end
            end
        end
        @(posedge clk);
    endtask

    task automatic beat(input bit v, input bit sp, input bit sy, input bit af,
                        input logic [DW-1:0] d, input string tag);
        step(1, 0, 1, '0, 0, v, sp, sy, af, d, tag);
    endtask

    task automatic arm(input logic [AW-1:0] a, input int w, input bit dir, input string tag);
        step(1, 1, dir, a, w, 0, 0, 0, 0, '0, tag);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) step(0, 0, 1, '0, 0, 0, 0, 0, 0, '0, "reset");
        step(1, 0, 1, '0, 0, 0, 0, 0, 0, '0, "R1");
        // R2: traffic with nothing armed is discarded
        beat(1, 1, 0, 0, 16'h0101, "R2");
        beat(1, 0, 1, 0, 16'h0102, "R2");
        beat(1, 1, 1, 1, 16'h0103, "R2");
        // R3 / R4: arm, then a plain, a sync and a sop beat
        arm(16'h1234, 3, 1, "R3");
        beat(1, 0, 0, 0, 16'h0201, "R4");
        beat(1, 0, 1, 0, 16'h0202, "R4");
        beat(1, 1, 0, 0, 16'h0203, "R4");
        // R6: back-pressure while passing
        beat(1, 0, 0, 1, 16'h0204, "R6");
        beat(0, 0, 0, 0, 16'h0205, "R6");
        beat(1, 0, 0, 0, 16'h0206, "R6");
        beat(1, 0, 0, 0, 16'h0207, "R7");
        beat(1, 0, 0, 0, 16'h0208, "R7");
        beat(0, 0, 0, 0, 16'h0209, "R7");
        // R5: release beat under almost-full is discarded
        arm(16'h2000, 2, 1, "R5");
        beat(1, 1, 1, 1, 16'h0301, "R5");
        beat(1, 1, 1, 0, 16'h0302, "R5");
        beat(1, 0, 0, 0, 16'h0303, "R5");
        beat(0, 0, 0, 0, 16'h0304, "R7");
        // R8: direction flips to read mid-access
        arm(16'h3000, 4, 1, "R8");
        beat(1, 1, 1, 0, 16'h0401, "R8");
        step(1, 0, 0, '0, 0, 1, 0, 0, 0, 16'h0402, "R8");
        step(1, 0, 0, '0, 0, 1, 1, 1, 0, 16'h0403, "R8");
        beat(1, 1, 1, 0, 16'h0404, "R8");
        // R9: ignored arm requests
        arm(16'h4444, 2, 0, "R9");
        beat(1, 1, 1, 0, 16'h0501, "R9");
        arm(16'h5555, 0, 1, "R9");
        beat(1, 1, 1, 0, 16'h0502, "R9");
        arm(16'h6000, 2, 1, "R9");
        arm(16'h6666, 3, 1, "R9");
        // R7 / R9: arm on the completing beat (ignored), then on done (taken)
        step(1, 1, 1, 16'h7777, 3, 1, 1, 1, 0, 16'h0601, "R9");
        step(1, 1, 1, 16'h7777, 3, 1, 0, 0, 0, 16'h0602, "R9");
        step(1, 1, 1, 16'h8888, 1, 0, 0, 0, 0, 16'h0603, "R7");
        beat(1, 1, 1, 0, 16'h0604, "R7");
        beat(0, 0, 0, 0, 16'h0605, "R7");
        // Random mixture
        for (int i = 0; i < 4000; i++) begin
            step(1, ($urandom % 8) == 0, ($urandom % 10) != 0, AW'($urandom), 1 + ($urandom % 4),
                 ($urandom % 10) < 7, ($urandom % 4) == 0, ($urandom % 5) == 0,
                 ($urandom % 5) == 0, DW'($urandom), "RND");
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule